// File: doc/BRIEF.md
# Presettable Synchronous 4-Bit Binary Counter

The block is a four-bit synchronous binary counter with a parallel load, an active-low clear, two count enables and a terminal-count carry. Both enables must be high for the counter to advance. Only one of them, the carry enable, also gates the carry output. This lets a chain of stages be built in which the upper stage advances only when the lower one wraps. A parameter selects how the clear is timed. It either forces zero at once, independent of the clock, or it takes effect on the next rising edge.

A second counter instance inside the top shows how the load reduces the modulus. Its carry, inverted, drives its own load, and its data input is tied to six. The effective sequence is therefore six through fifteen, and the counter repeats every ten edges. This second counter shares the clock, the clear and the two enables with the main counter.

Top module: `presettable_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, clear_n low forces count to 0000 without waiting for a clock edge.
- R2: With ASYNC_CLEAR=0, clear_n low sets count to 0000 only at the next rising clock edge, and count keeps its value until that edge.
- R3: Clear has priority over load and counting: a rising edge with clear_n low always leaves count at 0000, whatever load_n, the enables and din are.
- R4: With clear_n high and load_n low, a rising edge copies din into count, even when both enables are low.
- R5: Load has priority over counting. With clear_n and load_n high and enable_p and enable_t both high, a rising edge adds one to count modulo 16.
- R6: With clear_n and load_n high and either enable low, count holds its value across the edge.
- R7: carry is 1 exactly when enable_t is 1 and count is 1111. It drops to 0 when enable_t goes low. From 1111 a counting edge gives 0000.
- R8: The modulus-ten counter loads 0110 on the edge after it reaches 1111 with enable_t high. After a clear it runs 0 to 15 once, then 6 to 15 with a period of ten. dec_carry is 1 at 1111 whenever enable_t is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear for both counters; its timing is set by ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load of the main counter |
| enable_p | input | 1 | Count enable that does not affect the carry |
| enable_t | input | 1 | Count enable that also gates the carry |
| din | input | 4 | Parallel load value for the main counter |
| count | output | 4 | Main counter value |
| carry | output | 1 | Main terminal-count carry |
| dec_count | output | 4 | Modulus-ten counter value |
| dec_carry | output | 1 | Modulus-ten counter carry, which also drives its reload |

## Verification
The assertions assume that every low pulse on clear_n spans at least one rising clock edge. They also assume that clear_n does not drop between two edges after a load or count edge that they are judging. The load and count properties compare against the value sampled one edge later, and a clear in between would break that. The bench changes inputs only on falling edges. It holds each clear across a rising edge and lifts the mid-cycle asynchronous clear only after the following edge. A copy of the top with ASYNC_CLEAR=0 receives the same inputs, so both clear timings are exercised under these same limits.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int CTR_W = 4;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } ctr_op_e;

  // Priority: clear, then load, then count; otherwise hold.
  function automatic ctr_op_e pick_op(input logic clr_n, input logic ld_n,
                                      input logic en_p, input logic en_t);
    if (!clr_n)            return OP_CLEAR;
    else if (!ld_n)        return OP_LOAD;
    else if (en_p && en_t) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction

  function automatic logic [CTR_W-1:0] step(input logic [CTR_W-1:0] v);
    return v + CTR_W'(1);
  endfunction

  function automatic logic at_top(input logic [CTR_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int W = CTR_W
) (
  input  ctr_op_e      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ld_val;
      OP_COUNT: nxt = step(cur);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int W           = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= nxt;
      end
    end else begin : g_sync
      // nxt is already zero when clear_n is low
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_unit.sv
module ctr_unit
  import ctr_pkg::*;
#(
  parameter int W           = CTR_W,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         enable_p,
  input  logic         enable_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  ctr_op_e      op;
  logic [W-1:0] nxt;

  always_comb op = pick_op(clear_n, load_n, enable_p, enable_t);

  ctr_next #(.W(W)) u_next (
    .op    (op),
    .cur   (q),
    .ld_val(din),
    .nxt   (nxt)
  );

  ctr_state_reg #(.W(W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk    (clk),
    .clear_n(clear_n),
    .nxt    (nxt),
    .q      (q)
  );

  assign tc = enable_t & at_top(q);
endmodule

// File: rtl/ctr_mod_wrap.sv
module ctr_mod_wrap
  import ctr_pkg::*;
#(
  parameter int W           = CTR_W,
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int START       = 6
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         enable_p,
  input  logic         enable_t,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] START_V = W'(START);

  logic reload_n;
  assign reload_n = ~tc;

  ctr_unit #(.W(W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_cnt (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (reload_n),
    .enable_p(enable_p),
    .enable_t(enable_t),
    .din     (START_V),
    .q       (q),
    .tc      (tc)
  );
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int DEC_START   = 6
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             enable_p,
  input  logic             enable_t,
  input  logic [CTR_W-1:0] din,
  output logic [CTR_W-1:0] count,
  output logic             carry,
  output logic [CTR_W-1:0] dec_count,
  output logic             dec_carry
);
  // Event: a counting edge is pending while the main counter sits at its top
  logic main_wrap_evt;
  assign main_wrap_evt = carry & enable_p & clear_n & load_n;

  ctr_unit #(.W(CTR_W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_main (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (load_n),
    .enable_p(enable_p),
    .enable_t(enable_t),
    .din     (din),
    .q       (count),
    .tc      (carry)
  );

  ctr_mod_wrap #(.W(CTR_W), .ASYNC_CLEAR(ASYNC_CLEAR), .START(DEC_START)) u_dec (
    .clk     (clk),
    .clear_n (clear_n),
    .enable_p(enable_p),
    .enable_t(enable_t),
    .q       (dec_count),
    .tc      (dec_carry)
  );
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int DEC_START   = 6
) (
  input logic       clk,
  input logic       clear_n,
  input logic       load_n,
  input logic       enable_p,
  input logic       enable_t,
  input logic [3:0] din,
  input logic [3:0] count,
  input logic       carry,
  input logic [3:0] dec_count,
  input logic       dec_carry,
  input logic       main_wrap_evt
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1: asynchronous clear already visible between edges
  a_r1_async_clear: assert property (@(negedge clk)
    started && ASYNC_CLEAR && !clear_n |-> count == 4'd0 && dec_count == 4'd0);

  // R2 / R3: an edge seen with clear low leaves zero in both timings
  a_r3_clear_wins: assert property (@(posedge clk)
    started && !$past(clear_n) |-> count == 4'd0 && dec_count == 4'd0);

  // R4: load copies din regardless of enables
  a_r4_load: assert property (@(posedge clk)
    started && $past(clear_n) && !$past(load_n) && clear_n |-> count == $past(din));

  // R5: counting edge adds one
  a_r5_count: assert property (@(posedge clk)
    started && $past(clear_n) && $past(load_n) && $past(enable_p) && $past(enable_t) && clear_n
    |-> count == 4'($past(count) + 4'd1));

  // R6: hold when an enable is low
  a_r6_hold: assert property (@(posedge clk)
    started && $past(clear_n) && $past(load_n) && !($past(enable_p) && $past(enable_t)) && clear_n
    |-> count == $past(count));

  // R7: carry only at all-ones with enable_t high, then wrap to zero
  a_r7_carry_top: assert property (@(posedge clk)
    started && carry |-> count == 4'hF && enable_t);
  a_r7_wrap: assert property (@(posedge clk)
    started && main_wrap_evt |=> count == 4'd0);

  // R8: modulus-ten reload from the top value
  a_r8_reload: assert property (@(posedge clk)
    started && $past(dec_count) == 4'hF && $past(clear_n) && $past(enable_t) && clear_n
    |-> dec_count == 4'(DEC_START) && !dec_carry);
endmodule

bind presettable_counter presettable_counter_chk #(
  .ASYNC_CLEAR(ASYNC_CLEAR),
  .DEC_START  (DEC_START)
) u_chk (
  .clk          (clk),
  .clear_n      (clear_n),
  .load_n       (load_n),
  .enable_p     (enable_p),
  .enable_t     (enable_t),
  .din          (din),
  .count        (count),
  .carry        (carry),
  .dec_count    (dec_count),
  .dec_carry    (dec_carry),
  .main_wrap_evt(main_wrap_evt)
);

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
  logic       clk = 1'b0;
  logic       clear_n, load_n, enable_p, enable_t;
  logic [3:0] din;
  logic [3:0] count, dec_count, count_s, dec_count_s;
  logic       carry, dec_carry, carry_s, dec_carry_s;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  presettable_counter #(.ASYNC_CLEAR(1'b1)) i_presettable_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .din(din), .count(count), .carry(carry),
    .dec_count(dec_count), .dec_carry(dec_carry));

  presettable_counter #(.ASYNC_CLEAR(1'b0)) i_presettable_counter_sync (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .din(din), .count(count_s), .carry(carry_s),
    .dec_count(dec_count_s), .dec_carry(dec_carry_s));

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // {req[3:0], clear_n, load_n, enable_p, enable_t, din[3:0], exp_count[3:0], exp_carry}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {4'd3, 4'b0111, 4'h0, 4'h0, 1'b0}, // R3 clear at edge
    {4'd5, 4'b1111, 4'h0, 4'h1, 1'b0}, // R5 count
    {4'd5, 4'b1111, 4'h0, 4'h2, 1'b0}, // R5 count
    {4'd4, 4'b1000, 4'hD, 4'hD, 1'b0}, // R4 load with enables low
    {4'd5, 4'b1111, 4'h0, 4'hE, 1'b0}, // R5 count
    {4'd7, 4'b1111, 4'h0, 4'hF, 1'b1}, // R7 carry at top
    {4'd7, 4'b1110, 4'h0, 4'hF, 1'b0}, // R7 / R6 enable_t low drops carry, holds
    {4'd6, 4'b1101, 4'h0, 4'hF, 1'b1}, // R6 enable_p low holds
    {4'd7, 4'b1111, 4'h0, 4'h0, 1'b0}, // R7 wrap to zero
    {4'd3, 4'b0011, 4'h9, 4'h0, 1'b0}, // R3 clear beats load
    {4'd5, 4'b1011, 4'h5, 4'h5, 1'b0}, // R5 load beats count
    {4'd5, 4'b1111, 4'h0, 4'h6, 1'b0}, // R5 count
    {4'd6, 4'b1100, 4'h0, 4'h6, 1'b0}  // R6 both enables low
  };

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_n = 1'b0; load_n = 1'b1; enable_p = 1'b0; enable_t = 1'b0; din = 4'h0;
    repeat (2) @(posedge clk);
    #5;
    check("R3 reset state", {count, carry}, 5'h00);
    check("R2 reset state sync", {count_s, carry_s}, 5'h00);

    // table walk: drive at falling edge, sample 5 ns after the rising edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clear_n, load_n, enable_p, enable_t} = VEC[i][12:9];
      din = VEC[i][8:5];
      @(posedge clk);
      #5;
      check($sformatf("R%0d vector %0d", VEC[i][16:13], i), {count, carry}, VEC[i][4:0]);
      check($sformatf("R%0d vector %0d sync", VEC[i][16:13], i), {count_s, carry_s}, VEC[i][4:0]);
    end

    // R1 / R2: mid-cycle clear, counters at 6
    @(negedge clk);
    #3;
    clear_n = 1'b0;
    #3;
    check("R1 async clear immediate", {1'b0, count}, 5'h00);
    check("R2 sync clear waits", {1'b0, count_s}, 5'h06);
    @(posedge clk);
    #5;
    check("R2 sync clear at edge", {1'b0, count_s}, 5'h00);

    // R8: modulus-ten sequence from clear
    @(negedge clk);
    clear_n = 1'b1; load_n = 1'b1; enable_p = 1'b1; enable_t = 1'b1;
    begin
      logic [3:0] m;
      m = 4'd0;
      for (int k = 0; k < 32; k++) begin
        @(posedge clk);
        #5;
        m = (m == 4'hF) ? 4'd6 : 4'(m + 4'd1);
        check("R8 mod-10 sequence", {dec_count, dec_carry}, {m, m == 4'hF});
        check("R8 mod-10 sequence sync", {dec_count_s, dec_carry_s}, {m, m == 4'hF});
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule